// File: doc/BRIEF.md
# Translation Buffer with Hardware Table Walk

This block turns 32-bit virtual byte addresses into 28-bit physical byte addresses. Pages are 4 KB. A small fully associative buffer holds recent translations. A request whose page is in the buffer is answered in the next cycle. On a miss, the block fetches the page-table entry from main memory by itself. It then installs the translation, if the entry is marked valid, and answers. If the entry is not valid, it answers with a fault.

The table is a flat array of 32-bit words in main memory. The entry for a virtual page is found at the byte address formed by adding the base register to four times the page number, taken modulo 2^32. Writing the base register, for example on a change of address space, empties the buffer. The requester offers one address at a time and waits while `req_ready` is low. The memory side holds a read request until it is acknowledged. The acknowledgement carries the data.

Top module: `tlb_walker`

## Requirements
- R1: After reset, `rsp_valid` and `mem_rd_req` are low, `req_ready` is high, and the buffer holds no translation, so the first request of any page starts a table read.
- R2: A request accepted while its virtual page number (address bits 31:12) is in the buffer gives `rsp_valid` high in the following cycle, with `rsp_fault` low and `rsp_paddr` equal to the stored 16-bit frame number placed above the unchanged 12-bit offset. No memory read is issued.
- R3: A request that misses raises `mem_rd_req` in the following cycle, with `mem_rd_addr` = base + 4 × page number (modulo 2^32). Request and address stay unchanged, and `req_ready` stays low, until `mem_rd_ack` is seen.
- R4: When `mem_rd_ack` arrives with entry bit 31 set, `rsp_valid` rises in the next cycle with `rsp_fault` low and `rsp_paddr` = {entry bits 15:0, offset}. The translation is installed, so a later request to the same page is a hit.
- R5: When `mem_rd_ack` arrives with entry bit 31 clear, the response has `rsp_fault` high and `rsp_paddr` zero. Nothing is installed, so a repeated request to that page reads memory again.
- R6: The buffer holds 8 translations and is refilled in round-robin order, starting at slot 0 after reset or after a base write. Installing a ninth page evicts the first page installed, and the other eight stay hits.
- R7: A write to the base register discards every buffered translation. Later misses read entries relative to the new base.
- R8: Every accepted request produces exactly one `rsp_valid` pulse of one cycle. Without a request, `rsp_valid` stays low.
- R9: Entry bits 30:16 are ignored and do not appear in the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_vaddr | input | 32 | Virtual byte address |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 28 | Physical byte address (zero on fault) |
| rsp_fault | output | 1 | Page fault: the entry was not valid |
| mem_rd_req | output | 1 | Table-entry read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_ack | input | 1 | Read complete; data valid this cycle |
| mem_rd_data | input | 32 | Entry word: bit 31 valid, bits 15:0 frame number |
| base_wr_en | input | 1 | Write the base register and flush the buffer |
| base_wr_data | input | 32 | New table base address |

## Verification
The hardest state to reach from the ports is a full buffer whose round-robin pointer has wrapped. In that state, which page gets evicted depends on the whole history of valid installs, and faulting reads must not advance the pointer. The bench sweeps a list of pages in which every seventh page has a non-valid entry. It runs the list forward, again forward and then in reverse, with memory latencies from zero to three cycles. A small reference model of the slots and the pointer predicts hit or miss for each access. A base write and a directed fill of nine pages then check the flush and the eviction of the oldest entry.

// File: rtl/tlb_pkg.sv
// Package: shared types for the translation unit.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tlb_pkg;

    // Walk controller state
    typedef enum logic [0:0] {
        WS_IDLE = 1'b0,
        WS_WALK = 1'b1
    } walk_state_t;

endpackage

// File: rtl/tlb_cam.sv
// tlb_cam: fully associative store of page-number / frame-number pairs.
// Compares a lookup page number against all slots in parallel and returns
// a one-hot match vector plus the matching frame.
// Assumes at most one slot matches (installs happen only after a miss).
// A flush clears every valid bit and wins over a same-cycle install.
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               ins_en,
    input  logic [IDX_W-1:0]   ins_idx,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PFN_W-1:0]   ins_pfn,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] hit_vec,
    output logic               hit,
    output logic [PFN_W-1:0]   hit_pfn
);

    logic [ENTRIES-1:0]            slot_v;
    logic [ENTRIES-1:0][VPN_W-1:0] slot_vpn;
    logic [ENTRIES-1:0][PFN_W-1:0] slot_pfn;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Per-slot storage: flush clears, install writes the selected slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[g]   <= 1'b0;
                slot_vpn[g] <= '0;
                slot_pfn[g] <= '0;
            end else if (flush) begin
                slot_v[g]   <= 1'b0;
            end else if (ins_en && (ins_idx == IDX_W'(g))) begin
                slot_v[g]   <= 1'b1;
                slot_vpn[g] <= ins_vpn;
                slot_pfn[g] <= ins_pfn;
            end
        end

        // Per-slot tag compare
        assign hit_vec[g] = slot_v[g] && (slot_vpn[g] == lk_vpn);
    end

    // Merge matching frame numbers (one-hot by assumption)
    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_pfn = hit_pfn | slot_pfn[i];
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/tlb_rr_ptr.sv
// tlb_rr_ptr: round-robin victim pointer for the translation store.
// Advances by one on each install and wraps after ENTRIES installs.
// Returns to slot 0 on reset and on flush.
module tlb_rr_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);

    // Pointer update with wrap at ENTRIES-1
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            idx <= '0;
        end else if (adv) begin
            idx <= (idx == IDX_W'(ENTRIES - 1)) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_walk_fsm.sv
// tlb_walk_fsm: controls the table walk that follows a lookup miss.
// IDLE accepts requests. A miss moves to WALK, which lasts until the memory
// acknowledges the entry read. Assumes the ack arrives only while in WALK.
module tlb_walk_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_fire,
    input  logic lookup_hit,
    input  logic mem_ack,
    output logic walking,
    output logic walk_start,
    output logic walk_done
);
    import tlb_pkg::*;

    walk_state_t state_q;

    // Event decode for the datapath
    assign walking    = (state_q == WS_WALK);
    assign walk_start = req_fire && !lookup_hit;
    assign walk_done  = walking && mem_ack;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            case (state_q)
                WS_IDLE: if (walk_start) state_q <= WS_WALK;
                WS_WALK: if (mem_ack)    state_q <= WS_IDLE;
                default:                 state_q <= WS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tlb_walker.sv
// tlb_walker: translation unit with an associative buffer and a single-level
// hardware table walk. Entry address = base + 4 * page number. Entry bit
// PTE_W-1 is the valid flag; the low PFN_W bits hold the frame number.
// Assumes the base register is written only while no walk is in flight.
module tlb_walker #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 28,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 8,
    parameter int PTE_W   = 32,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PFN_W  = PA_W - OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int VBIT   = PTE_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_rd_req,
    output logic [VA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic             base_wr_en,
    input  logic [VA_W-1:0]  base_wr_data
);

    logic               req_fire;
    logic               walking;
    logic               walk_start;
    logic               walk_done;
    logic               lk_hit;
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [PFN_W-1:0]   lk_pfn;
    logic [IDX_W-1:0]   victim;
    logic               install;
    logic [VPN_W-1:0]   req_vpn;
    logic [OFF_W-1:0]   req_off;
    logic [VPN_W-1:0]   pend_vpn;
    logic [OFF_W-1:0]   pend_off;
    logic [VA_W-1:0]    base_q;
    logic               pte_ok;
    logic [PFN_W-1:0]   pte_pfn;

    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign req_ready = !walking;
    assign req_fire  = req_valid && req_ready;
    assign pte_ok    = mem_rd_data[VBIT];
    assign pte_pfn   = mem_rd_data[PFN_W-1:0];
    assign install   = walk_done && pte_ok && !base_wr_en;
    assign mem_rd_req = walking;

    tlb_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .lookup_hit (lk_hit),
        .mem_ack    (mem_rd_ack),
        .walking    (walking),
        .walk_start (walk_start),
        .walk_done  (walk_done)
    );

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (base_wr_en),
        .ins_en  (install),
        .ins_idx (victim),
        .ins_vpn (pend_vpn),
        .ins_pfn (pte_pfn),
        .lk_vpn  (req_vpn),
        .hit_vec (lk_hit_vec),
        .hit     (lk_hit),
        .hit_pfn (lk_pfn)
    );

    tlb_rr_ptr #(
        .ENTRIES (ENTRIES)
    ) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (base_wr_en),
        .adv   (install),
        .idx   (victim)
    );

    // Base register
    always_ff @(posedge clk) begin
        if (!rst_n)          base_q <= '0;
        else if (base_wr_en) base_q <= base_wr_data;
    end

    // Capture the missing request and form the entry address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vpn    <= '0;
            pend_off    <= '0;
            mem_rd_addr <= '0;
        end else if (walk_start) begin
            pend_vpn    <= req_vpn;
            pend_off    <= req_off;
            mem_rd_addr <= base_q + {{(VA_W-VPN_W-2){1'b0}}, req_vpn, 2'b00};
        end
    end

    // Response register: hit answer or walk result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= (req_fire && lk_hit) || walk_done;
            if (req_fire && lk_hit) begin
                rsp_fault <= 1'b0;
                rsp_paddr <= {lk_pfn, req_off};
            end else if (walk_done) begin
                rsp_fault <= !pte_ok;
                rsp_paddr <= pte_ok ? {pte_pfn, pend_off} : '0;
            end
        end
    end

endmodule

// File: rtl/tlb_walker_chk.sv
// tlb_walker_chk: protocol and response properties of tlb_walker.
// Attached to every tlb_walker instance via bind.
module tlb_walker_chk #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 28,
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               mem_rd_req,
    input logic               mem_rd_ack,
    input logic [VA_W-1:0]    mem_rd_addr,
    input logic [ENTRIES-1:0] hit_vec,
    input logic               lk_hit
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !mem_rd_req));

    // R2
    hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (rsp_valid && !rsp_fault && !mem_rd_req));

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R3
    walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R8
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready && lk_hit) || $past(mem_rd_req && mem_rd_ack)));

endmodule

bind tlb_walker tlb_walker_chk #(
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .ENTRIES (ENTRIES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_addr (mem_rd_addr),
    .hit_vec     (lk_hit_vec),
    .lk_hit      (lk_hit)
);

// File: tb/tlb_walker_tb.sv
`timescale 1ns/1ps
// Bench: sweeps page sequences against a reference model of the slots.
module tlb_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [27:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] cur_base = '0;
    logic [19:0] m_vpn [8];
    bit          m_v   [8];
    int          m_ptr = 0;

    always #2.5 clk = ~clk;

    tlb_walker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_fault    (rsp_fault),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ack   (mem_rd_ack),
        .mem_rd_data  (mem_rd_data),
        .base_wr_en   (base_wr_en),
        .base_wr_data (base_wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Table contents: every seventh page is not valid; bits 30:16 hold junk (R9)
    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        logic ok;
        logic [15:0] pfn;
        ok  = (vpn % 7) != 6;
        pfn = vpn[15:0] * 16'd13 + 16'd5;
        return {ok, vpn[14:0] ^ 15'h5A5A, pfn};
    endfunction

    function automatic bit model_hit(input logic [19:0] vpn);
        for (int k = 0; k < 8; k++) if (m_v[k] && m_vpn[k] == vpn) return 1'b1;
        return 1'b0;
    endfunction

    task automatic clear_model();
        for (int k = 0; k < 8; k++) m_v[k] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic set_base(input logic [31:0] b);
        base_wr_en   = 1'b1;
        base_wr_data = b;
        @(negedge clk);
        base_wr_en   = 1'b0;
        cur_base     = b;
        clear_model();
    endtask

    // One translation; hit/miss predicted by the model
    task automatic xlate(input logic [19:0] vpn, input logic [11:0] off, input int lat, input string tag);
        logic [31:0] pte;
        logic [31:0] exp_addr;
        logic [31:0] exp_pa;
        bit          exp_hit;
        exp_hit  = model_hit(vpn);
        pte      = pte_of(vpn);
        exp_addr = cur_base + {10'b0, vpn, 2'b00};
        exp_pa   = {4'b0, pte[15:0], off};
        chk(req_ready, {tag, " R3 ready when idle"}, {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            chk(rsp_valid && !rsp_fault && !mem_rd_req && {4'b0, rsp_paddr} == exp_pa,
                {tag, " R2 R6 hit response"}, {4'b0, rsp_paddr}, exp_pa);
        end else begin
            chk(mem_rd_req && !rsp_valid && mem_rd_addr == exp_addr,
                {tag, " R3 R6 R7 miss entry address"}, mem_rd_addr, exp_addr);
            repeat (lat) @(negedge clk);
            chk(mem_rd_req && !req_ready && !rsp_valid && mem_rd_addr == exp_addr,
                {tag, " R3 walk held"}, mem_rd_addr, exp_addr);
            mem_rd_ack  = 1'b1;
            mem_rd_data = pte;
            @(negedge clk);
            mem_rd_ack  = 1'b0;
            mem_rd_data = '0;
            if (pte[31]) begin
                chk(rsp_valid && !rsp_fault && {4'b0, rsp_paddr} == exp_pa,
                    {tag, " R4 R9 refill response"}, {4'b0, rsp_paddr}, exp_pa);
                m_vpn[m_ptr] = vpn;
                m_v[m_ptr]   = 1'b1;
                m_ptr        = (m_ptr + 1) % 8;
            end else begin
                chk(rsp_valid && rsp_fault && rsp_paddr == '0,
                    {tag, " R5 fault response"}, {3'b0, rsp_fault, rsp_paddr}, 32'h1000_0000);
            end
        end
        @(negedge clk);
        chk(!rsp_valid, {tag, " R8 single pulse"}, {31'b0, rsp_valid}, 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!rsp_valid && !mem_rd_req && req_ready, "R1 reset outputs",
            {29'b0, rsp_valid, mem_rd_req, req_ready}, 32'd1);
        xlate(20'h00123, 12'h456, 0, "R1 first access misses");

        set_base(32'h0010_0000);
        // Sweep: forward, forward again, reverse; latency 0..3
        for (int pass = 0; pass < 3; pass++) begin
            for (int i = 0; i < 12; i++) begin
                int j;
                j = (pass == 2) ? 11 - i : i;
                xlate(20'(j * 37 + 16), 12'((i * 341 + pass * 7) & 12'hFFF), (i + pass) % 4, "sweep");
            end
        end
        // Fault page repeated: still reads memory (R5)
        xlate(20'd90, 12'h000, 1, "R5 repeat");
        xlate(20'd90, 12'hFFF, 0, "R5 repeat");

        // R7: new base flushes; previously hit page misses at new base
        xlate(20'd16, 12'h010, 0, "R7 before");
        set_base(32'hFFFF_F000);
        chk(!model_hit(20'd16), "R7 model flushed", 32'd0, 32'd0);
        xlate(20'd16, 12'h010, 2, "R7 after");
        xlate(20'hFFFFF, 12'hFFF, 1, "R7 top page wrap");

        // R6: nine valid pages, first evicted, the rest hit
        set_base(32'h0200_0000);
        for (int i = 0; i < 9; i++) xlate(20'(i * 7 + 1), 12'(i), 0, "R6 fill");
        for (int i = 1; i < 9; i++) begin
            chk(model_hit(20'(i * 7 + 1)), "R6 model survivor", 32'd1, 32'd1);
            xlate(20'(i * 7 + 1), 12'hABC, 0, "R6 survivor");
        end
        chk(!model_hit(20'd1), "R6 oldest evicted", 32'd0, 32'd0);
        xlate(20'd1, 12'h321, 3, "R6 evicted page");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule